// File: doc/BRIEF.md
# Buffered SPI Master with Bus-Contention Detection

This block is an SPI master that handles 8-bit characters. It sits behind a processor-side register interface. A write to the transmit holding register is the only event that starts a character. Transmit and receive run at the same time, so fetching a byte from a slave also needs a write, even if the written byte is a dummy. The holding register moves into the transmit shifter only when the shifter is empty. The `tx_ready_o` flag reports that move. The `rx_done_o` flag reports that a whole exchange has finished and that the received byte is in the receive holding register.

The serial clock is generated from a programmable divider. Each clock half lasts `div_i + 1` system clocks, and the serial clock rests low between characters. When the holding register is refilled before the current character ends, the next character follows with no idle time.

In 4-pin operation the `ste_i` input shows whether the bus is free. While it is low, another master is assumed to own the bus. The block then drops the enables of its serial clock and data outputs and sets a sticky error flag. It keeps all of its state and freezes the character in progress until `ste_i` returns high. In 3-pin operation `ste_i` has no effect. `ste_i` must already be synchronous to `clk_i`.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, `tx_ready_o`=1, `rx_done_o`=0, `fe_o`=0, `sclk_o`=0, and both output enables are 1.
- R2: A write on `tx_wr_i` is the only thing that starts a character. With no write pending, `sclk_o` stays low.
- R3: `mosi_o` presents the transmitted byte MSB first. Each bit is stable while `sclk_o` is high.
- R4: `miso_i` is sampled when `sclk_o` rises and is assembled MSB first. When the character ends, the assembled byte appears on `rx_data_o`.
- R5: `rx_done_o` is set in the cycle in which the eighth falling edge of `sclk_o` appears.
- R6: `tx_wr_i` clears `tx_ready_o` in the following cycle. `tx_ready_o` is set again once the holding register moves into an empty shifter, which happens before the first rising edge of `sclk_o`.
- R7: Each high phase and each low phase of `sclk_o` inside a burst lasts `div_i+1` clocks.
- R8: If the holding register is full when a character ends, the next character begins at once. The low phase between the two characters is the normal `div_i+1` clocks.
- R9: `rx_rd_i` clears `rx_done_o` on the next cycle, unless a character ends in that same cycle.
- R10: When `four_pin_i`=1 and `ste_i`=0, both output enables go low and `fe_o` is set on the next cycle.
- R11: A contention does not reset the block. The character in progress is frozen and then resumes, and it completes with correct data once `ste_i` returns high.
- R12: `fe_o` stays set until `fe_clr_i` is pulsed while no contention is present.
- R13: With `four_pin_i`=0, `ste_i` has no effect: the enables stay 1, `fe_o` stays 0, and transfers complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| four_pin_i | input | 1 | 1 selects 4-pin operation, in which `ste_i` is watched |
| div_i | input | DIV_W | Half-period divider; each half lasts `div_i+1` clocks |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | 8 | Byte to transmit |
| rx_rd_i | input | 1 | Read strobe for the receive holding register; clears `rx_done_o` |
| rx_data_o | output | 8 | Receive holding register |
| fe_clr_i | input | 1 | Write-1-to-clear for `fe_o` |
| tx_ready_o | output | 1 | Transmit holding register is free to accept a byte |
| rx_done_o | output | 1 | A full exchange has completed |
| fe_o | output | 1 | Sticky bus-contention error |
| sclk_o | output | 1 | Serial clock; rests low |
| sclk_oe_o | output | 1 | Output enable for `sclk_o` |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Output enable for `mosi_o` |
| miso_i | input | 1 | Serial data in |
| ste_i | input | 1 | Bus-free indication; low means another master is active |

## Verification
The hardest situations to reach are a contention that lands in the middle of a character and the handover between back-to-back characters. In the handover, the holding register has to be refilled inside the window between `tx_ready_o` rising and the eighth falling clock edge. The bench refills the register as soon as it sees `tx_ready_o` high. Its slave model measures every clock phase, so a missing or extra cycle between the two characters shows up as a wrong low-phase width. For contention, the bench waits for a chosen number of serial-clock edges and then pulls `ste_i` low in the middle of a bit. It checks that the enables drop and that the clock freezes. After `ste_i` returns high, it checks that the received and transmitted bytes still match what the slave model expects.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int unsigned CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = active_i & run_i & (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_dbuf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  char_t load_data_i,
  input  logic  tick_i,
  input  logic  miso_i,
  output logic  active_o,
  output logic  sclk_o,
  output logic  mosi_o,
  output logic  done_o,
  output char_t rx_o
);
  localparam int unsigned CNT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

  logic             active_q, phase_q;
  logic [CNT_W-1:0] bcnt_q;
  char_t            tsh_q, rsh_q;

  assign active_o = active_q;
  assign sclk_o   = phase_q;
  assign mosi_o   = tsh_q[CHAR_W-1];
  assign rx_o     = rsh_q;
  assign done_o   = tick_i & active_q & phase_q & (bcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      bcnt_q   <= '0;
      tsh_q    <= '0;
      rsh_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      bcnt_q   <= '0;
      tsh_q    <= load_data_i;
    end else if (tick_i && active_q) begin
      if (!phase_q) begin
        rsh_q   <= {rsh_q[CHAR_W-2:0], miso_i};
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (bcnt_q == LAST) begin
          active_q <= 1'b0;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
          tsh_q  <= {tsh_q[CHAR_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbuf_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             four_pin_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_wr_i,
  input  logic [7:0]       tx_data_i,
  input  logic             rx_rd_i,
  output logic [7:0]       rx_data_o,
  input  logic             fe_clr_i,
  output logic             tx_ready_o,
  output logic             rx_done_o,
  output logic             fe_o,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  input  logic             miso_i,
  input  logic             ste_i
);
  char_t hold_q, rx_buf_q, rx_sh;
  logic  hold_full_q, tx_ready_q, rx_done_q, fe_q;
  logic  contention, active, tick, done, start;

  assign contention = four_pin_i & ~ste_i;
  // refill the shifter when idle or in the very cycle it finishes
  assign start = hold_full_q & (~active | done) & ~contention;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .run_i   (~contention),
    .div_i   (div_i),
    .tick_o  (tick)
  );

  spi_shift_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_data_i(hold_q),
    .tick_i     (tick),
    .miso_i     (miso_i),
    .active_o   (active),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .done_o     (done),
    .rx_o       (rx_sh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      tx_ready_q  <= 1'b1;
      rx_buf_q    <= '0;
      rx_done_q   <= 1'b0;
      fe_q        <= 1'b0;
    end else begin
      if (tx_wr_i) hold_q <= tx_data_i;
      // a write in the start cycle refills the buffer: write wins
      if (tx_wr_i)    hold_full_q <= 1'b1;
      else if (start) hold_full_q <= 1'b0;
      if (tx_wr_i)    tx_ready_q <= 1'b0;
      else if (start) tx_ready_q <= 1'b1;
      if (done) rx_buf_q <= rx_sh;
      if (done)         rx_done_q <= 1'b1;
      else if (rx_rd_i) rx_done_q <= 1'b0;
      if (contention)    fe_q <= 1'b1;
      else if (fe_clr_i) fe_q <= 1'b0;
    end
  end

  assign rx_data_o  = rx_buf_q;
  assign tx_ready_o = tx_ready_q;
  assign rx_done_o  = rx_done_q;
  assign fe_o       = fe_q;
  assign sclk_oe_o  = ~contention;
  assign mosi_oe_o  = ~contention;
endmodule

module spi_dbuf_master_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic four_pin_i,
  input logic ste_i,
  input logic tx_wr_i,
  input logic rx_rd_i,
  input logic fe_clr_i,
  input logic tx_ready_o,
  input logic rx_done_o,
  input logic fe_o,
  input logic sclk_o,
  input logic sclk_oe_o,
  input logic mosi_oe_o
);
  // R6
  wr_clears_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> !tx_ready_o);
  // R9
  rd_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !sclk_o) |=> !rx_done_o);
  // R5
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> $fell(sclk_o));
  // R10
  fault_sets_fe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_pin_i && !ste_i) |=> fe_o);
  // R11
  fault_freezes_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_pin_i && !ste_i) |=> $stable(sclk_o));
  // R12
  fe_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_o && !fe_clr_i) |=> fe_o);
  // R13
  three_pin_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !four_pin_i |-> (sclk_oe_o && mosi_oe_o));
endmodule

bind spi_dbuf_master spi_dbuf_master_chk #(.DIV_W(DIV_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .four_pin_i(four_pin_i), .ste_i(ste_i),
  .tx_wr_i(tx_wr_i), .rx_rd_i(rx_rd_i), .fe_clr_i(fe_clr_i),
  .tx_ready_o(tx_ready_o), .rx_done_o(rx_done_o), .fe_o(fe_o),
  .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .mosi_oe_o(mosi_oe_o)
);

// File: tb/spi_dbuf_master_tb_top.sv
module spi_dbuf_master_tb_top;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic four_pin = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0, fe_clr = 1'b0, ste = 1'b1;
  logic [DIV_W-1:0] div = '0;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_ready, rx_done, fe, sclk, sclk_oe, mosi, mosi_oe, miso;

  always #4 clk = ~clk;

  spi_dbuf_master #(.DIV_W(DIV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .four_pin_i(four_pin), .div_i(div),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .rx_data_o(rx_data),
    .fe_clr_i(fe_clr), .tx_ready_o(tx_ready), .rx_done_o(rx_done), .fe_o(fe),
    .sclk_o(sclk), .sclk_oe_o(sclk_oe), .mosi_o(mosi), .mosi_oe_o(mosi_oe),
    .miso_i(miso), .ste_i(ste)
  );

  int checks = 0, errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model
  logic [7:0] sl_q [0:63];
  logic [7:0] got_q [0:63];
  int frame = 0, sl_bit = 0, hi_cnt = 0, lo_cnt = 0;
  logic [7:0] sl_sh = '0, sl_rx = '0;
  logic prev_sclk = 1'b0;
  bit width_en = 1'b0, skip_lo = 1'b1;
  assign miso = sl_sh[7];

  function automatic int half_clocks(input logic [DIV_W-1:0] d);
    return int'(d) + 1;
  endfunction

  always @(negedge clk) begin
    if (sclk == prev_sclk) begin
      if (sclk) hi_cnt++; else lo_cnt++;
    end else if (sclk) begin
      sl_rx = {sl_rx[6:0], mosi};
      // R7 R8 low phase, including gap between back-to-back characters
      if (width_en && !skip_lo) chk(lo_cnt == half_clocks(div), "R7/R8 low width", lo_cnt, half_clocks(div));
      skip_lo = 1'b0;
      hi_cnt = 1;
    end else begin
      // R7 high phase
      if (width_en) chk(hi_cnt == half_clocks(div), "R7 high width", hi_cnt, half_clocks(div));
      lo_cnt = 1;
      sl_bit++;
      if (sl_bit == 8) begin
        got_q[frame] = sl_rx;
        frame++;
        sl_bit = 0;
        sl_sh = sl_q[frame];
      end else sl_sh = {sl_sh[6:0], 1'b0};
    end
    prev_sclk = sclk;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 5000 && !rx_done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_rx;
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  // one character from idle; checks R3 R4 R5
  task automatic frame_chk(input logic [7:0] d, input string tag);
    int f;
    f = frame;
    skip_lo = 1'b1;
    write(d);
    wait_done();
    chk(rx_done == 1'b1, {tag, " R5 done"}, rx_done, 1);
    chk(frame == f + 1, {tag, " R5 frame count"}, frame, f + 1);
    chk(got_q[f] == d, {tag, " R3 mosi"}, got_q[f], d);
    chk(rx_data == sl_q[f], {tag, " R4 miso"}, rx_data, sl_q[f]);
    read_rx();
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) sl_q[i] = 8'($urandom);
    sl_sh = sl_q[0];
    cyc(2);
    // R1 reset state
    chk(tx_ready == 1 && rx_done == 0 && fe == 0, "R1 flags", {tx_ready, rx_done, fe}, 3'b100);
    chk(sclk == 0 && sclk_oe && mosi_oe, "R1 pins", {sclk, sclk_oe, mosi_oe}, 3'b011);
    rst_n = 1'b1;
    cyc(2);
    width_en = 1'b1;

    // R2 nothing happens without a write
    cyc(30);
    chk(sclk == 0 && frame == 0, "R2 idle", frame, 0);

    // R6 tx_ready handshake
    div = 8'd2; skip_lo = 1'b1;
    tx_data = 8'hA5; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    chk(tx_ready == 0, "R6 cleared", tx_ready, 0);
    @(negedge clk);
    chk(tx_ready == 1 && sclk == 0 && !rx_done, "R6 early ready", {tx_ready, sclk, rx_done}, 3'b100);
    wait_done();
    chk(got_q[0] == 8'hA5, "R3 mosi", got_q[0], 8'hA5);
    chk(rx_data == sl_q[0], "R4 miso", rx_data, sl_q[0]);
    // R9 read clears
    read_rx();
    chk(rx_done == 0, "R9 clear", rx_done, 0);

    frame_chk(8'h00, "div2");
    div = 8'd0;
    frame_chk(8'hFF, "div0");
    frame_chk(8'h81, "div0");

    // R8 back-to-back: refill as soon as ready
    div = 8'd1; skip_lo = 1'b1;
    begin
      int f;
      f = frame;
      write(8'h5A);
      for (int i = 0; i < 50 && !tx_ready; i++) @(negedge clk);
      write(8'hC3);
      wait_done(); read_rx();
      wait_done();
      chk(frame == f + 2, "R8 two chars", frame, f + 2);
      chk(got_q[f] == 8'h5A && got_q[f+1] == 8'hC3, "R8 mosi", got_q[f+1], 8'hC3);
      chk(rx_data == sl_q[f+1], "R8 miso", rx_data, sl_q[f+1]);
      read_rx();
    end

    // R13 3-pin ignores ste
    four_pin = 1'b0; div = 8'd1; skip_lo = 1'b1;
    begin
      int f;
      f = frame;
      write(8'h3C);
      cyc(5); ste = 1'b0; cyc(3);
      chk(sclk_oe && mosi_oe && !fe, "R13 no fault", {sclk_oe, mosi_oe, fe}, 3'b110);
      wait_done();
      ste = 1'b1;
      chk(got_q[f] == 8'h3C && rx_data == sl_q[f], "R13 data", rx_data, sl_q[f]);
      read_rx();
    end

    // R10 R11 R12 contention mid-character in 4-pin mode
    four_pin = 1'b1; div = 8'd1; skip_lo = 1'b1;
    begin
      int f;
      logic s;
      f = frame;
      write(8'h96);
      cyc(9);
      ste = 1'b0; width_en = 1'b0;
      @(negedge clk);
      s = sclk;
      chk(!sclk_oe && !mosi_oe, "R10 enables off", {sclk_oe, mosi_oe}, 0);
      chk(fe == 1, "R10 fe set", fe, 1);
      cyc(20);
      chk(sclk == s && frame == f, "R11 frozen", sclk, s);
      fe_clr = 1'b1; @(negedge clk); fe_clr = 1'b0;
      chk(fe == 1, "R12 clear blocked during fault", fe, 1);
      ste = 1'b1;
      wait_done();
      chk(got_q[f] == 8'h96 && rx_data == sl_q[f], "R11 resume data", rx_data, sl_q[f]);
      chk(fe == 1 && sclk_oe && mosi_oe, "R12 fe sticky", {fe, sclk_oe, mosi_oe}, 3'b111);
      fe_clr = 1'b1; @(negedge clk); fe_clr = 1'b0;
      chk(fe == 0, "R12 cleared", fe, 0);
      read_rx();
      width_en = 1'b1;
    end

    // random frames, 3-pin and 4-pin with ste high
    for (int k = 0; k < 20 && frame < 60; k++) begin
      four_pin = 1'($urandom);
      div = 8'($urandom_range(0, 5));
      frame_chk(8'($urandom), "rand");
    end

    // R2 again: idle after traffic
    begin
      int f;
      f = frame;
      cyc(40);
      chk(frame == f && sclk == 0 && !rx_done, "R2 idle after", frame, f);
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule